// File: doc/BRIEF.md
# Pipelined Microcode Control Unit

This block is the control path of a microcoded processor. A next-address sequencer picks the address of the microinstruction to fetch. A microprogram ROM reads that word, and a pipeline register holds the microinstruction being executed. The held word drives two things in the same cycle. Its datapath control field goes out to an external datapath. Its control-path fields (next-address mode, branch target and condition select) go back to the sequencer and the condition multiplexer.

Fetch overlaps execution. While the word in the pipeline register executes, the ROM is already reading the word at the address the sequencer has just formed. The cycle time is therefore bounded by the slower of fetch and execute, not by their sum. The ROM output only reaches the ROM address through the pipeline register, so the loop from ROM back to ROM address is never purely combinational. The microprogram is computed inside the code. Each word's datapath field is `8'hA0` XOR its own address, so the exported field shows which word is executing.

Top module: `mcu_ctrl_top`

## Requirements
- R1: While reset is asserted, `dp_ctrl_o` is 0 and `fetch_addr_o` is 0. The pipeline register holds an all-zero no-operation word with step mode.
- R2: Mode 2'b00 (step) fetches the sequencer counter. The counter always holds the previous fetch address plus one.
- R3: Mode 2'b01 (zero) makes the fetch address 0.
- R4: Mode 2'b10 (jump) makes the fetch address equal to the branch target field.
- R5: Mode 2'b11 (test) fetches the branch target when the selected condition is true, and the counter value otherwise.
- R6: Condition select 0 is a constant true. Selects 1, 2 and 3 pick `cc_i[0]`, `cc_i[1]` and `cc_i[2]`.
- R7: A word fetched at `fetch_addr_o` in one cycle reaches `dp_ctrl_o` after the next rising clock edge, and its datapath field is `8'hA0 ^ address`.
- R8: The sequencer counter wraps modulo 2^AW, so step mode from the top address fetches address 0.
- R9: The built-in microprogram follows this flow:
  - Addresses 0 and 1 step, and 2 jumps to 8.
  - Word 8 tests select 1 and branches to 12. Words 9 and 10 then step and zero.
  - Word 12 tests select 0 and branches to 16. Word 16 tests select 2 and branches to 20, and word 17 jumps to 24.
  - Word 20 tests select 3 and branches to 26, and word 21 jumps to 24.
  - Word 24 zeros, word 26 jumps to 31, and every other word steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cc_i | input | 3 | Condition codes from the datapath (condition selects 1 to 3) |
| dp_ctrl_o | output | 8 | Datapath control field of the executing microinstruction |
| fetch_addr_o | output | 5 | Address the ROM is reading this cycle |

## Verification
The assertions assume that `cc_i` is known and stable in every cycle after reset. They also assume that reset is released away from the rising edge, so each cycle has exactly one executing word and one fetch address. The bench meets both assumptions. It changes `cc_i` only while reset is held and drives every input on the falling edge. Each of the four condition patterns steers the fixed microprogram down a different path. One further scenario asserts reset in the middle of a run.

// File: rtl/mcu_pkg.sv
package mcu_pkg;

    localparam int NX_W = 2;

    // Next-address modes of a microinstruction
    typedef enum logic [NX_W-1:0] {
        NX_STEP = 2'b00,
        NX_ZERO = 2'b01,
        NX_JUMP = 2'b10,
        NX_TEST = 2'b11
    } nxt_e;

endpackage

// File: rtl/mcu_ccmux.sv
module mcu_ccmux #(
    parameter int NCC = 4,
    localparam int CSW = $clog2(NCC)
) (
    input  logic [NCC-2:0] ext_i,
    input  logic [CSW-1:0] sel_i,
    output logic           cond_o
);

    logic [NCC-1:0] src;

    // Input 0 is tied true; the others come from the datapath
    assign src[0] = 1'b1;
    generate
        for (genvar g = 1; g < NCC; g++) begin : g_src
            assign src[g] = ext_i[g-1];
        end
    endgenerate

    assign cond_o = src[sel_i];

endmodule

// File: rtl/mcu_rom.sv
module mcu_rom #(
    parameter int AW  = 5,
    parameter int CW  = 8,
    parameter int CSW = 2,
    localparam int DEPTH = 1 << AW,
    localparam int UW    = mcu_pkg::NX_W + CSW + AW + CW
) (
    input  logic [AW-1:0] addr_i,
    output logic [UW-1:0] word_o
);
    import mcu_pkg::*;

    typedef logic [UW-1:0] rom_t [DEPTH];

    function automatic logic [UW-1:0] mk(input nxt_e nx, input int cs,
                                         input int br, input int idx);
        return {nx, CSW'(cs), AW'(br), CW'(idx) ^ CW'(8'hA0)};
    endfunction

    function automatic rom_t build();
        rom_t r;
        for (int i = 0; i < DEPTH; i++) r[i] = mk(NX_STEP, 0, 0, i);
        r[2]  = mk(NX_JUMP, 0, 8, 2);
        r[8]  = mk(NX_TEST, 1, 12, 8);
        r[10] = mk(NX_ZERO, 0, 0, 10);
        r[12] = mk(NX_TEST, 0, 16, 12);
        r[16] = mk(NX_TEST, 2, 20, 16);
        r[17] = mk(NX_JUMP, 0, 24, 17);
        r[20] = mk(NX_TEST, 3, 26, 20);
        r[21] = mk(NX_JUMP, 0, 24, 21);
        r[24] = mk(NX_ZERO, 0, 0, 24);
        r[26] = mk(NX_JUMP, 0, 31, 26);
        return r;
    endfunction

    localparam rom_t ROM = build();

    assign word_o = ROM[addr_i];

endmodule

// File: rtl/mcu_seq.sv
module mcu_seq
    import mcu_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  nxt_e          sel_i,
    input  logic [AW-1:0] br_i,
    input  logic          cond_i,
    output logic [AW-1:0] addr_o
);

    typedef struct packed {
        logic [AW-1:0] upc;
        logic          pv;
    } seq_st_t;

    seq_st_t seq_d, seq_q;

    always_comb begin
        unique case (sel_i)
            NX_STEP: addr_o = seq_q.upc;
            NX_ZERO: addr_o = '0;
            NX_JUMP: addr_o = br_i;
            NX_TEST: addr_o = cond_i ? br_i : seq_q.upc;
            default: addr_o = seq_q.upc;
        endcase
        seq_d.upc = addr_o + AW'(1);
        seq_d.pv  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    // R2 R8
    step_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.pv && sel_i == NX_STEP) |-> addr_o == AW'($past(addr_o) + 1'b1));

endmodule

// File: rtl/mcu_ctrl_top.sv
module mcu_ctrl_top
    import mcu_pkg::*;
#(
    parameter int AW  = 5,
    parameter int CW  = 8,
    parameter int NCC = 4,
    localparam int CSW   = $clog2(NCC),
    localparam int BR_LO = CW,
    localparam int CS_LO = CW + AW,
    localparam int NX_LO = CW + AW + CSW,
    localparam int UW    = NX_LO + NX_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCC-2:0] cc_i,
    output logic [CW-1:0]  dp_ctrl_o,
    output logic [AW-1:0]  fetch_addr_o
);

    typedef struct packed {
        logic [UW-1:0] pipe;
        logic          pv;
    } top_st_t;

    top_st_t top_d, top_q;

    logic [UW-1:0]  rom_word;
    logic [AW-1:0]  fetch_addr;
    logic           cond;
    nxt_e           nx_sel;
    logic [AW-1:0]  br_addr;
    logic [CSW-1:0] cc_sel;

    assign nx_sel  = nxt_e'(top_q.pipe[NX_LO +: NX_W]);
    assign br_addr = top_q.pipe[BR_LO +: AW];
    assign cc_sel  = top_q.pipe[CS_LO +: CSW];

    mcu_ccmux #(.NCC(NCC)) u_ccmux (
        .ext_i (cc_i),
        .sel_i (cc_sel),
        .cond_o(cond)
    );

    mcu_seq #(.AW(AW)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_i (nx_sel),
        .br_i  (br_addr),
        .cond_i(cond),
        .addr_o(fetch_addr)
    );

    mcu_rom #(.AW(AW), .CW(CW), .CSW(CSW)) u_rom (
        .addr_i(fetch_addr),
        .word_o(rom_word)
    );

    always_comb begin
        top_d.pipe = rom_word;
        top_d.pv   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign dp_ctrl_o    = top_q.pipe[CW-1:0];
    assign fetch_addr_o = fetch_addr;

    // R3
    zero_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nx_sel == NX_ZERO |-> fetch_addr == '0);

    // R4
    jump_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nx_sel == NX_JUMP |-> fetch_addr == br_addr);

    // R5
    test_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nx_sel == NX_TEST && cond) |-> fetch_addr == br_addr);

    // R5
    test_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.pv && nx_sel == NX_TEST && !cond)
            |-> fetch_addr == AW'($past(fetch_addr) + 1'b1));

    // R6
    always_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nx_sel == NX_TEST && cc_sel == '0) |-> fetch_addr == br_addr);

    // R7
    pipe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_q.pv |-> dp_ctrl_o == $past(rom_word[CW-1:0]));

endmodule

// File: tb/mcu_ctrl_top_tb.sv
module mcu_ctrl_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cc_i = '0;
    logic [7:0] dp_ctrl_o;
    logic [4:0] fetch_addr_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mcu_ctrl_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cc_i        (cc_i),
        .dp_ctrl_o   (dp_ctrl_o),
        .fetch_addr_o(fetch_addr_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R1: hold reset, verify the idle no-op state
    task automatic do_reset(input logic [2:0] cc);
        @(negedge clk);
        rst_n = 1'b0;
        cc_i  = cc;
        @(negedge clk);
        @(negedge clk);
        check("R1 dp_ctrl in reset", int'(dp_ctrl_o), 0);
        check("R1 fetch addr in reset", int'(fetch_addr_o), 0);
        rst_n = 1'b1;
    endtask

    // Walk an expected path of executed addresses (R7 datapath tag)
    task automatic run_path(input logic [2:0] cc, input int n,
                            input int seq[12], input string tag);
        do_reset(cc);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check({tag, " R7 executing word"}, int'(dp_ctrl_o), seq[i] ^ 'hA0);
            if (i + 1 < n)
                check({tag, " fetch address"}, int'(fetch_addr_o), seq[i+1]);
        end
    endtask

    // R2 R3 R5: condition 1 false, fall through, then zero
    task automatic t_fall_through();
        run_path(3'b000, 8, '{0, 1, 2, 8, 9, 10, 0, 1, 0, 0, 0, 0}, "R2 R3 R5 R9");
    endtask

    // R4 R5 R6: select 1 true, select 0 always true, select 2 false
    task automatic t_first_branch();
        run_path(3'b001, 9, '{0, 1, 2, 8, 12, 16, 17, 24, 0, 0, 0, 0}, "R4 R5 R6");
    endtask

    // R6: select 2 true, select 3 false
    task automatic t_second_branch();
        run_path(3'b011, 10, '{0, 1, 2, 8, 12, 16, 20, 21, 24, 0, 0, 0}, "R6");
    endtask

    // R8: path reaches address 31 and steps around to 0
    task automatic t_wrap();
        run_path(3'b111, 11, '{0, 1, 2, 8, 12, 16, 20, 26, 31, 0, 1, 0}, "R8 R6");
    endtask

    // R1: reset in the middle of a run returns to the idle state
    task automatic t_mid_reset();
        do_reset(3'b111);
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        check("R1 dp_ctrl after mid-run reset", int'(dp_ctrl_o), 0);
        check("R1 fetch after mid-run reset", int'(fetch_addr_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 R7 first word after release", int'(dp_ctrl_o), 'hA0);
        check("R2 fetch after release", int'(fetch_addr_o), 1);
    endtask

    initial begin
        t_fall_through();
        t_first_branch();
        t_second_branch();
        t_wrap();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule